// File: doc/BRIEF.md
# Dual-Resolution Successive-Approximation Conversion Sequencer

This block is the digital control for a charge-redistribution analog-to-digital converter that resolves either 12 or 8 bits per conversion. On each accepted request it walks through a fixed run of phases. First comes a purge that discharges the capacitor array. Then comes an auto-zero that stores comparator offsets, then input sampling, and finally one bit decision per clock. It builds the trial code for the capacitor DAC from the comparator answers and then reports the finished word with a one-cycle done pulse.

The DAC code is split into two 6-bit halves: a main half for the upper bits and a sub half for the lower bits. Two power-down outputs control the comparator. One switches off the whole comparator when no conversion is running. The other switches off the extra gain stages, which only the 12-bit mode needs. A global sleep input freezes the sequencer wherever it stands.

Top module: `dualres_sar_ctrl`

## Requirements
- R1: After an accepted request the phases run in this order: one purge cycle, then auto-zero, then two sample cycles, then the bit cycles. At most one of `purge_o`, `azero_o`, `sample_o`, `bit_cyc_o` is high in any cycle, and all four are low when idle.
- R2: With `mode8_i`=0 sampled alongside the request, the conversion has 2 auto-zero cycles and 12 bit cycles. `done_o` is high in the cycle after the 17th clock edge that follows the edge accepting the request.
- R3: With `mode8_i`=1 sampled alongside the request, the conversion has 1 auto-zero cycle and 8 bit cycles. `done_o` is high in the cycle after the 12th clock edge that follows the accepting edge.
- R4: The trial code is `{dac_main_o, dac_sub_o}`, with `dac_main_o` carrying bits 11..6 and `dac_sub_o` carrying bits 5..0. During the first bit cycle the code is 12'h800. Outside bit cycles it is 0.
- R5: Bits are decided from bit 11 downward. Each trial sets the bit under test. The bit is kept when `cmp_above_i`=1, which means the input is at or above the trial code. For an input level V, the 12-bit result is the largest code not above V.
- R6: In 8-bit mode the result occupies bits 11..4 of `data_o`, and bits 3..0 are 0. Bits 3..0 of the trial code are also 0 in every cycle of the conversion.
- R7: `done_o` is high for exactly one cycle. `data_o` keeps the result until the next done.
- R8: A request that arrives while a conversion is running has no effect: it does not restart the conversion and does not start another one afterwards.
- R9: While `sleep_i`=1 no state advances. The strobes and the DAC code hold, completion is delayed by exactly the number of sleeping cycles, and a request seen while idle and asleep is dropped.
- R10: `cmp_sleep_all_o` is high when idle or when `sleep_i`=1. `cmp_sleep_fine_o` is high whenever `cmp_sleep_all_o` is high, and also during any 8-bit conversion. Both are low during a 12-bit conversion while awake.
- R11: While `rst_n` is low, all strobes, `done_o`, `data_o` and the DAC code are 0, and `cmp_sleep_all_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_i | input | 1 | Global sleep: freezes the sequencer |
| conv_req_i | input | 1 | Conversion request, accepted only when idle and awake |
| mode8_i | input | 1 | 1 selects 8-bit, 0 selects 12-bit; sampled with the request |
| cmp_above_i | input | 1 | Comparator result: 1 when input is at or above the trial code |
| dac_main_o | output | 6 | Upper half of the trial code (bits 11..6) |
| dac_sub_o | output | 6 | Lower half of the trial code (bits 5..0) |
| purge_o | output | 1 | Purge phase strobe |
| azero_o | output | 1 | Auto-zero phase strobe |
| sample_o | output | 1 | Sample phase strobe |
| bit_cyc_o | output | 1 | Bit decision phase strobe |
| cmp_sleep_all_o | output | 1 | Power down the whole comparator |
| cmp_sleep_fine_o | output | 1 | Power down the stages only the 12-bit mode needs |
| data_o | output | 12 | Last conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs. `cmp_above_i` is a settled function of the current trial code at each clock edge. `sleep_i` and the request change only between edges. The phase lengths keep their default values. The stimulus meets these conditions: it models the comparator as a direct comparison of the trial code against a fixed input level, and it drives every input on the falling clock edge. It also holds the mode steady across each conversion and places sleep and stray requests in the middle of conversions at known cycles.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PURGE,
    PH_AZERO,
    PH_SAMPLE,
    PH_BITS
  } phase_e;
endpackage

// File: rtl/sar_phase_seq.sv
`timescale 1ns/1ps
module sar_phase_seq
  import sar_seq_pkg::*;
#(
  parameter int W         = 12,
  parameter int LO_BITS   = 8,
  parameter int PURGE_CYC = 1,
  parameter int AZ_HI     = 2,
  parameter int AZ_LO     = 1,
  parameter int SMP_CYC   = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_en,
  input  logic   start_i,
  input  logic   mode8_i,
  output phase_e phase_o,
  output logic   mode8_o,
  output logic   load_o,
  output logic   last_bit_o
);
  localparam int CW = $clog2(W + 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode8_q, mode8_d;
  logic [CW-1:0] phase_len;
  logic          phase_end;

  // length of the phase currently running
  always_comb begin
    case (phase_q)
      PH_PURGE:  phase_len = CW'(PURGE_CYC);
      PH_AZERO:  phase_len = mode8_q ? CW'(AZ_LO) : CW'(AZ_HI);
      PH_SAMPLE: phase_len = CW'(SMP_CYC);
      PH_BITS:   phase_len = mode8_q ? CW'(LO_BITS) : CW'(W);
      default:   phase_len = CW'(1);
    endcase
  end

  assign phase_end = (cnt_q == phase_len - CW'(1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mode8_d = mode8_q;
    if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_d = PH_PURGE;
        cnt_d   = '0;
        mode8_d = mode8_i;
      end
    end else if (phase_end) begin
      cnt_d = '0;
      case (phase_q)
        PH_PURGE:  phase_d = PH_AZERO;
        PH_AZERO:  phase_d = PH_SAMPLE;
        PH_SAMPLE: phase_d = PH_BITS;
        default:   phase_d = PH_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      mode8_q <= 1'b0;
    end else if (run_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mode8_q <= mode8_d;
    end
  end

  assign phase_o    = phase_q;
  assign mode8_o    = mode8_q;
  assign load_o     = (phase_q == PH_SAMPLE) && phase_end;
  assign last_bit_o = (phase_q == PH_BITS) && phase_end;

  p_purge_to_az_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && phase_q == PH_PURGE) |=> (phase_q == PH_AZERO));

  p_az_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && phase_q == PH_AZERO && mode8_q) |=> (phase_q == PH_SAMPLE));

  p_busy_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && phase_q != PH_IDLE) |=> (phase_q != PH_PURGE));

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en) |=> ($stable(phase_q) && $stable(cnt_q)));
endmodule

// File: rtl/sar_approx_reg.sv
`timescale 1ns/1ps
module sar_approx_reg #(
  parameter int W       = 12,
  parameter int LO_BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         last_i,
  input  logic         cmp_i,
  input  logic         mode8_i,
  output logic [W-1:0] dac_o,
  output logic [W-1:0] data_o,
  output logic         done_o
);
  localparam int PAD = W - LO_BITS;
  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ptr_q, ptr_d;
  logic [W-1:0] res_q, res_d;
  logic [W-1:0] data_q, data_d;
  logic         done_q;
  logic [W-1:0] kept;

  assign kept = cmp_i ? (res_q | ptr_q) : res_q;

  always_comb begin
    ptr_d  = ptr_q;
    res_d  = res_q;
    data_d = data_q;
    if (load_i) begin
      ptr_d = MSB_ONE;
      res_d = '0;
    end else if (step_i) begin
      if (last_i) begin
        data_d = kept;
        ptr_d  = '0;
        res_d  = '0;
      end else begin
        res_d = kept;
        ptr_d = ptr_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      res_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_en && step_i && last_i;
      if (run_en) begin
        ptr_q  <= ptr_d;
        res_q  <= res_d;
        data_q <= data_d;
      end
    end
  end

  assign dac_o  = res_q | ptr_q;
  assign data_o = data_q;
  assign done_o = done_q;

  p_ptr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q));

  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && load_i) |=> (ptr_q == MSB_ONE));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode8_i) |-> (data_q[PAD-1:0] == '0));
endmodule

// File: rtl/dualres_sar_ctrl.sv
`timescale 1ns/1ps
module dualres_sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int SUB_W     = 6,
  parameter int MAIN_W    = 6,
  parameter int LO_BITS   = 8,
  parameter int PURGE_CYC = 1,
  parameter int AZ_HI     = 2,
  parameter int AZ_LO     = 1,
  parameter int SMP_CYC   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_i,
  input  logic                    conv_req_i,
  input  logic                    mode8_i,
  input  logic                    cmp_above_i,
  output logic [MAIN_W-1:0]       dac_main_o,
  output logic [SUB_W-1:0]        dac_sub_o,
  output logic                    purge_o,
  output logic                    azero_o,
  output logic                    sample_o,
  output logic                    bit_cyc_o,
  output logic                    cmp_sleep_all_o,
  output logic                    cmp_sleep_fine_o,
  output logic [SUB_W+MAIN_W-1:0] data_o,
  output logic                    done_o
);
  localparam int W = SUB_W + MAIN_W;

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic         run_en;
  phase_e       phase;
  logic         mode8_q;
  logic         load_ptr;
  logic         last_bit;
  logic [W-1:0] dac_code;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign run_en = !sleep_i;

  sar_phase_seq #(
    .W(W), .LO_BITS(LO_BITS), .PURGE_CYC(PURGE_CYC),
    .AZ_HI(AZ_HI), .AZ_LO(AZ_LO), .SMP_CYC(SMP_CYC)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run_en     (run_en),
    .start_i    (conv_req_i),
    .mode8_i    (mode8_i),
    .phase_o    (phase),
    .mode8_o    (mode8_q),
    .load_o     (load_ptr),
    .last_bit_o (last_bit)
  );

  sar_approx_reg #(.W(W), .LO_BITS(LO_BITS)) u_sar (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_en  (run_en),
    .load_i  (load_ptr),
    .step_i  (phase == PH_BITS),
    .last_i  (last_bit),
    .cmp_i   (cmp_above_i),
    .mode8_i (mode8_q),
    .dac_o   (dac_code),
    .data_o  (data_o),
    .done_o  (done_o)
  );

  assign dac_main_o = dac_code[W-1:SUB_W];
  assign dac_sub_o  = dac_code[SUB_W-1:0];

  assign purge_o   = (phase == PH_PURGE);
  assign azero_o   = (phase == PH_AZERO);
  assign sample_o  = (phase == PH_SAMPLE);
  assign bit_cyc_o = (phase == PH_BITS);

  always_comb begin
    cmp_sleep_all_o  = (phase == PH_IDLE) || sleep_i;
    cmp_sleep_fine_o = cmp_sleep_all_o || mode8_q;
  end

  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({purge_o, azero_o, sample_o, bit_cyc_o}));

  p_fine_covers_all_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmp_sleep_all_o |-> cmp_sleep_fine_o);

  p_dac_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bit_cyc_o) |-> (dac_code == '0));
endmodule

// File: tb/test_dualres_sar_ctrl.sv
`timescale 1ns/1ps
module test_dualres_sar_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep;
  logic        req;
  logic        mode8;
  logic        cmp;
  logic [5:0]  dac_main, dac_sub;
  logic        purge, azero, sample, bitc;
  logic        slp_all, slp_fine;
  logic [11:0] data;
  logic        done;
  logic [11:0] vin;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit finished = 1'b0;
  bit done_prev = 1'b0;

  int          q_edge[$];
  logic [11:0] q_data[$];
  bit          q_m8[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) ecount <= ecount + 1;

  // comparator model: high when input level is at or above trial code
  assign cmp = ({dac_main, dac_sub} <= vin);

  dualres_sar_ctrl i_dualres_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .conv_req_i(req),
    .mode8_i(mode8), .cmp_above_i(cmp), .dac_main_o(dac_main),
    .dac_sub_o(dac_sub), .purge_o(purge), .azero_o(azero),
    .sample_o(sample), .bit_cyc_o(bitc), .cmp_sleep_all_o(slp_all),
    .cmp_sleep_fine_o(slp_fine), .data_o(data), .done_o(done)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  int          m_edge;
  logic [11:0] m_data;
  bit          m_m8;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && done_prev) chk(1'b0, "R7", "done longer than one cycle", 1, 0);
      if (done) begin
        if (q_data.size() == 0) begin
          chk(1'b0, "R8", "done without pending conversion", 1, 0);
        end else begin
          m_edge = q_edge.pop_front();
          m_data = q_data.pop_front();
          m_m8   = q_m8.pop_front();
          chk(data == m_data, m_m8 ? "R6" : "R5", "result word", data, m_data);
          chk(ecount == m_edge, m_m8 ? "R3" : "R2", "done edge", ecount, m_edge);
        end
      end
      done_prev = done;
    end
  end

  // driver: one conversion with optional sleep window and stray request
  task automatic convert(input bit m8, input logic [11:0] v,
                         input int slp_at, input int slp_len, input int ign_at);
    int total = m8 ? 12 : 17;
    int az = m8 ? 1 : 2;
    int c;
    logic [11:0] expd;
    logic [15:0] snap;
    @(negedge clk);
    vin = v; mode8 = m8; req = 1'b1;
    c = ecount;
    expd = m8 ? (v & 12'hFF0) : v;
    q_data.push_back(expd);
    q_edge.push_back(c + 1 + total + slp_len);
    q_m8.push_back(m8);
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      req = (i == ign_at);
      chk({purge, azero, sample, bitc} ==
          {i == 1, (i >= 2) && (i < 2 + az), (i >= 2 + az) && (i < 4 + az), i >= 4 + az},
          "R1", "phase strobes", {purge, azero, sample, bitc}, i);
      chk(slp_all == 1'b0 && slp_fine == m8, "R10", "comparator sleep",
          {slp_all, slp_fine}, {1'b0, m8});
      if (i == 4 + az)
        chk(dac_main == 6'h20 && dac_sub == 6'h00, "R4", "first trial split",
            {dac_main, dac_sub}, 12'h800);
      if (i < 4 + az)
        chk({dac_main, dac_sub} == 12'h000, "R4", "code outside bit cycles",
            {dac_main, dac_sub}, 0);
      if (m8)
        chk(dac_sub[3:0] == 4'h0, "R6", "low trial bits in 8-bit mode", dac_sub[3:0], 0);
      if (i == slp_at) begin
        snap = {purge, azero, sample, bitc, dac_main, dac_sub};
        sleep = 1'b1;
        for (int k = 0; k < slp_len; k++) begin
          @(negedge clk);
          chk({purge, azero, sample, bitc, dac_main, dac_sub} == snap, "R9",
              "frozen state", {purge, azero, sample, bitc, dac_main, dac_sub}, snap);
          chk(slp_all == 1'b1, "R10", "sleep forces comparator off", slp_all, 1);
        end
        sleep = 1'b0;
      end
    end
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(q_data.size() == 0, "R7", "conversion completed", q_data.size(), 0);
    chk(data == expd, "R7", "result held after done", data, expd);
    chk(slp_all && slp_fine, "R10", "idle comparator off", {slp_all, slp_fine}, 3);
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; sleep = 1'b0; req = 1'b0; mode8 = 1'b0; vin = 12'h000;
    repeat (3) @(negedge clk);
    chk({purge, azero, sample, bitc} == 4'b0, "R11", "reset strobes",
        {purge, azero, sample, bitc}, 0);
    chk(done == 1'b0 && data == 12'h000, "R11", "reset result", data, 0);
    chk({dac_main, dac_sub} == 12'h000, "R11", "reset code", {dac_main, dac_sub}, 0);
    chk(slp_all == 1'b1, "R11", "reset comparator off", slp_all, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // 12-bit patterns (R2, R5)
    convert(1'b0, 12'hA5C, 0, 0, 0);
    convert(1'b0, 12'hFFF, 0, 0, 0);
    convert(1'b0, 12'h000, 0, 0, 0);
    convert(1'b0, 12'h800, 0, 0, 0);
    convert(1'b0, 12'h7FF, 0, 0, 0);
    // 8-bit patterns (R3, R6)
    convert(1'b1, 12'h37A, 0, 0, 0);
    convert(1'b1, 12'hFFF, 0, 0, 0);
    convert(1'b1, 12'h00F, 0, 0, 0);

    // R8: stray request mid-conversion
    convert(1'b0, 12'h3C1, 0, 0, 6);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(!done && !purge, "R8", "no conversion after stray request", {done, purge}, 0);
    end
    convert(1'b1, 12'hC4E, 0, 0, 5);

    // R9: sleep in the middle of conversions
    convert(1'b0, 12'h5A5, 9, 5, 0);
    convert(1'b1, 12'h9B3, 3, 4, 0);

    // R9: request while idle and asleep is dropped
    @(negedge clk);
    sleep = 1'b1; req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!purge && slp_all, "R9", "asleep request not taken", {purge, slp_all}, 1);
    end
    sleep = 1'b0; req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!purge && !done, "R9", "no late start after sleep", {purge, done}, 0);
    end

    summary();
  end
endmodule